// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block translates a 32-bit virtual address with 4 KiB pages into a physical page address by searching a small set-associative table of translation entries. A request carries the virtual address, an access kind (load, store or instruction fetch) and a context word that holds the running process ID. The low bits of the virtual page number select one set, and every way of that set is compared at the same time. One cycle later the block returns a hit flag, the physical page address, the read/write/execute permissions of the matching entry, and a flag saying whether that entry allows the requested kind of access.

The entry table is loaded through a maintenance write port. That port takes a raw tag word, a raw data word and a way number. The set is taken from the page number inside the tag word. Each entry is held as a tag word, which packs the page number, a global flag, a valid flag and a process ID, and a data word, which packs the frame number and the permission bits. Page-table walking, fault generation and cache control belong to other blocks.

Top module: `tlbl_lookup`

## Requirements
- R1: A request accepted with `req_vld` high at a rising edge produces `rsp_vld` high for exactly the following cycle. Whenever `rsp_vld` is low, `rsp_hit`, `rsp_paddr`, `rsp_perm` and `rsp_ok` are zero. Reset clears these outputs and sets every tag and data word in the table to zero.
- R2: The virtual page number is `req_vaddr[31:12]`. Its low log2(ENTRIES/WAYS) bits select the set. The entry for way w and set s sits at index w*(ENTRIES/WAYS)+s. A maintenance write (`mnt_we` high at an edge) stores `mnt_tag` and `mnt_data` into way `mnt_way` of the set given by the low set-index bits of `mnt_tag[31:12]`.
- R3: A tag word holds the page number in bits 31:12, the global flag in bit 11, the valid flag in bit 10 and the process ID in bits PID_W-1:0. A way matches when its page number equals the request page number and either its global flag is set or its process ID equals the current one. The valid flag is not consulted.
- R4: The current process ID is `ctx_word[4 +: PID_W]`. All other context bits have no effect on the result.
- R5: On a hit, `rsp_paddr` equals data bits 19:0 (the frame number) shifted left by 12. Bits 11:0 are zero, so the page offset of the request has no effect.
- R6: The data word carries execute in bit 20, write in bit 21, read in bit 22 and a cacheable flag in bit 23. `rsp_perm` gives read in bit 0, write in bit 1 and execute in bit 2. The cacheable flag and data bits 31:24 do not appear in any output.
- R7: When several ways of the set match, the lowest-numbered way supplies the result.
- R8: On a miss, `rsp_hit`, `rsp_paddr`, `rsp_perm` and `rsp_ok` are all zero while `rsp_vld` is high.
- R9: `req_acc` encodes 0 load, 1 store, 2 fetch. `rsp_ok` is high on a hit whose read, write or execute permission matches that kind. Code 3 never grants.
- R10: A lookup in the same cycle as a maintenance write to the entry it matches sees the contents from before that write. The next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| ctx_word | input | 32 | Context word; process ID at bit 4 upward |
| mnt_we | input | 1 | Maintenance write strobe |
| mnt_way | input | log2(WAYS) | Way receiving the maintenance write |
| mnt_tag | input | 32 | Raw tag word to store |
| mnt_data | input | 32 | Raw data word to store |
| rsp_vld | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | A way matched |
| rsp_paddr | output | 32 | Physical page address, offset bits zero |
| rsp_perm | output | 3 | {execute, write, read} of the matching entry |
| rsp_ok | output | 1 | Matching entry grants the requested access kind |

## Verification
Every way and set of a 4-way, 4-set table is loaded with a distinct page, process ID, frame and permission pattern, with one way global. Each entry is then looked up with all four access codes, which separates the permission bits and the grant decode. The same pages are tried with a wrong process ID, which separates global from private entries, and with a different page number that falls in the same set, which exposes partial tag compares. Junk in the page offset, in the unused context bits and in the unused data bits shows whether any of them leak into the result. Further directed cases build double and triple matches in one set to test the priority, clear the valid flag, and write an entry in the same cycle as a lookup of it.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

    localparam int ADDR_W   = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = ADDR_W - PG_SHIFT;
    localparam int PFN_W    = 20;
    localparam int TAG_GLB  = 11;
    localparam int TAG_VLD  = 10;
    localparam int DAT_W    = 24;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic             cache;
        logic             r;
        logic             w;
        logic             x;
        logic [PFN_W-1:0] pfn;
    } dat_t;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [ADDR_W-1:0] paddr;
        perm_t             perm;
        logic              ok;
    } rsp_t;

    function automatic logic perm_grants(input perm_t p, input acc_e a);
        logic g;
        case (a)
            ACC_LOAD:  g = p.r;
            ACC_STORE: g = p.w;
            ACC_FETCH: g = p.x;
            default:   g = 1'b0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tlbl_store.sv
module tlbl_store
    import tlbl_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int SETS    = 16,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int ENTRIES = WAYS * SETS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic [ADDR_W-1:0]   wr_tag,
    input  dat_t                wr_dat,
    input  logic [SET_W-1:0]    rd_set,
    output logic [ADDR_W-1:0]   rd_tag [WAYS],
    output dat_t                rd_dat [WAYS]
);

    localparam int IDX_W = WAY_W + SET_W;

    logic [ADDR_W-1:0] tag_q [ENTRIES];
    logic [ADDR_W-1:0] tag_d [ENTRIES];
    dat_t              dat_q [ENTRIES];
    dat_t              dat_d [ENTRIES];
    logic [IDX_W-1:0]  wr_idx;

    // index = way * SETS + set, with SETS a power of two
    assign wr_idx = {wr_way, wr_tag[PG_SHIFT +: SET_W]};

    always_comb begin
        tag_d = tag_q;
        dat_d = dat_q;
        if (wr_en) begin
            tag_d[wr_idx] = wr_tag;
            dat_d[wr_idx] = wr_dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            tag_q <= tag_d;
            dat_q <= dat_d;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w] = tag_q[{WAY_W'(w), rd_set}];
        assign rd_dat[w] = dat_q[{WAY_W'(w), rd_set}];
    end

endmodule

// File: rtl/tlbl_match.sv
module tlbl_match
    import tlbl_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int PID_W = 8
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PID_W-1:0]  pid,
    input  logic [ADDR_W-1:0] tags [WAYS],
    output logic [WAYS-1:0]   hit_vec
);

    logic [WAYS-1:0] tag_unused;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic page_eq;
        logic pid_ok;
        assign page_eq    = (tags[w][ADDR_W-1:PG_SHIFT] == vpn);
        assign pid_ok     = tags[w][TAG_GLB] || (tags[w][PID_W-1:0] == pid);
        assign hit_vec[w] = page_eq && pid_ok;
        // valid flag and spare bits between it and the PID are not compared
        assign tag_unused[w] = ^tags[w][TAG_VLD:PID_W];
    end

endmodule

// File: rtl/tlbl_prio.sv
module tlbl_prio #(
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  req,
    output logic             any,
    output logic [WAY_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = WAY_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/tlbl_lookup.sv
module tlbl_lookup
    import tlbl_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int ENTRIES = 64,
    parameter int PID_W   = 8,
    localparam int SETS   = ENTRIES / WAYS,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [31:0]       ctx_word,
    input  logic              mnt_we,
    input  logic [WAY_W-1:0]  mnt_way,
    input  logic [31:0]       mnt_tag,
    input  logic [31:0]       mnt_data,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic [31:0]       rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic              rsp_ok
);

    localparam int PID_LSB = 4;

    logic [VPN_W-1:0]  req_vpn;
    logic [SET_W-1:0]  req_set;
    logic [PID_W-1:0]  cur_pid;
    logic [ADDR_W-1:0] set_tag [WAYS];
    dat_t              set_dat [WAYS];
    logic [WAYS-1:0]   way_hit;
    logic              any_hit;
    logic [WAY_W-1:0]  sel_way;
    dat_t              sel_dat;
    rsp_t              rsp_d;
    rsp_t              rsp_q;
    logic [WAYS-1:0]   cache_unused;
    logic              lk_unused;

    assign req_vpn = req_vaddr[ADDR_W-1:PG_SHIFT];
    assign req_set = req_vpn[SET_W-1:0];
    assign cur_pid = ctx_word[PID_LSB +: PID_W];

    tlbl_store #(
        .WAYS (WAYS),
        .SETS (SETS)
    ) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mnt_we),
        .wr_way (mnt_way),
        .wr_tag (mnt_tag),
        .wr_dat (dat_t'(mnt_data[DAT_W-1:0])),
        .rd_set (req_set),
        .rd_tag (set_tag),
        .rd_dat (set_dat)
    );

    tlbl_match #(
        .WAYS  (WAYS),
        .PID_W (PID_W)
    ) match_i (
        .vpn     (req_vpn),
        .pid     (cur_pid),
        .tags    (set_tag),
        .hit_vec (way_hit)
    );

    tlbl_prio #(
        .WAYS (WAYS)
    ) prio_i (
        .req (way_hit),
        .any (any_hit),
        .idx (sel_way)
    );

    assign sel_dat = set_dat[sel_way];

    always_comb begin
        rsp_d = '0;
        if (req_vld) begin
            rsp_d.vld = 1'b1;
            if (any_hit) begin
                rsp_d.hit    = 1'b1;
                rsp_d.paddr  = {sel_dat.pfn, {PG_SHIFT{1'b0}}};
                rsp_d.perm.r = sel_dat.r;
                rsp_d.perm.w = sel_dat.w;
                rsp_d.perm.x = sel_dat.x;
                rsp_d.ok     = perm_grants(rsp_d.perm, acc_e'(req_acc));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld   = rsp_q.vld;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_perm  = rsp_q.perm;
    assign rsp_ok    = rsp_q.ok;

    for (genvar w = 0; w < WAYS; w++) begin : g_cache
        assign cache_unused[w] = set_dat[w].cache;
    end

    assign lk_unused = ^{req_vaddr[PG_SHIFT-1:0], ctx_word[PID_LSB-1:0],
                         ctx_word[31:PID_LSB+PID_W], mnt_data[31:DAT_W],
                         cache_unused};

endmodule

// File: rtl/tlbl_lookup_chk.sv
module tlbl_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic [1:0]  req_acc,
    input logic        rsp_vld,
    input logic        rsp_hit,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_perm,
    input logic        rsp_ok
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld); // R1

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_hit && rsp_paddr == 32'h0 && rsp_perm == 3'b000 && !rsp_ok)); // R1

    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_paddr[11:0] == 12'h000)); // R5

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_hit) |-> (rsp_paddr == 32'h0 && rsp_perm == 3'b000 && !rsp_ok)); // R8

    AST_GRANT_BY_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_hit) |->
            (rsp_ok == (($past(req_acc) == 2'd0 && rsp_perm[0]) ||
                        ($past(req_acc) == 2'd1 && rsp_perm[1]) ||
                        ($past(req_acc) == 2'd2 && rsp_perm[2])))); // R9

endmodule

bind tlbl_lookup tlbl_lookup_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_acc   (req_acc),
    .rsp_vld   (rsp_vld),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_perm  (rsp_perm),
    .rsp_ok    (rsp_ok)
);

// File: tb/tlbl_lookup_tb.sv
module tlbl_lookup_tb_top;

    localparam int WAYS    = 4;
    localparam int ENTRIES = 16;
    localparam int PID_W   = 8;
    localparam int SETS    = ENTRIES / WAYS;
    localparam int WAY_W   = $clog2(WAYS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_vld = 1'b0;
    logic [31:0]       req_vaddr = '0;
    logic [1:0]        req_acc = '0;
    logic [31:0]       ctx_word = '0;
    logic              mnt_we = 1'b0;
    logic [WAY_W-1:0]  mnt_way = '0;
    logic [31:0]       mnt_tag = '0;
    logic [31:0]       mnt_data = '0;
    logic              rsp_vld;
    logic              rsp_hit;
    logic [31:0]       rsp_paddr;
    logic [2:0]        rsp_perm;
    logic              rsp_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_tag [ENTRIES];
    logic [31:0] m_dat [ENTRIES];

    always #2 clk = ~clk;

    tlbl_lookup #(
        .WAYS    (WAYS),
        .ENTRIES (ENTRIES),
        .PID_W   (PID_W)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .req_vaddr (req_vaddr),
        .req_acc   (req_acc),
        .ctx_word  (ctx_word),
        .mnt_we    (mnt_we),
        .mnt_way   (mnt_way),
        .mnt_tag   (mnt_tag),
        .mnt_data  (mnt_data),
        .rsp_vld   (rsp_vld),
        .rsp_hit   (rsp_hit),
        .rsp_paddr (rsp_paddr),
        .rsp_perm  (rsp_perm),
        .rsp_ok    (rsp_ok)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %08h expected %08h", rq, what, got, exp);
        end
    endtask

    // expected result from the requirements: first matching way in order
    task automatic model(input logic [31:0] va, input logic [1:0] acc,
                         input logic [31:0] ctx, output logic e_hit,
                         output logic [31:0] e_pa, output logic [2:0] e_pm,
                         output logic e_ok);
        logic [19:0] vpn;
        logic [7:0]  pid;
        int          set;
        vpn   = va[31:12];
        set   = int'(vpn) % SETS;
        pid   = ctx[11:4];
        e_hit = 1'b0;
        e_pa  = '0;
        e_pm  = '0;
        e_ok  = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            logic [31:0] t;
            logic [31:0] d;
            t = m_tag[w * SETS + set];
            d = m_dat[w * SETS + set];
            if (t[31:12] == vpn && (t[11] || t[7:0] == pid)) begin
                e_hit = 1'b1;
                e_pa  = {d[19:0], 12'h000};
                e_pm  = {d[20], d[21], d[22]};
            end
        end
        if (e_hit) begin
            case (acc)
                2'd0:    e_ok = e_pm[0];
                2'd1:    e_ok = e_pm[1];
                2'd2:    e_ok = e_pm[2];
                default: e_ok = 1'b0;
            endcase
        end
    endtask

    task automatic compare(input string rq, input logic e_hit, input logic [31:0] e_pa,
                           input logic [2:0] e_pm, input logic e_ok);
        chk(rq, "vld",   32'(rsp_vld),   32'd1);
        chk(rq, "hit",   32'(rsp_hit),   32'(e_hit));
        chk(rq, "paddr", rsp_paddr,      e_pa);
        chk(rq, "perm",  32'(rsp_perm),  32'(e_pm));
        chk(rq, "ok",    32'(rsp_ok),    32'(e_ok));
    endtask

    task automatic mwrite(input int way, input logic [31:0] tag, input logic [31:0] dat);
        @(negedge clk);
        mnt_we   = 1'b1;
        mnt_way  = WAY_W'(way);
        mnt_tag  = tag;
        mnt_data = dat;
        m_tag[way * SETS + int'(tag[13:12])] = tag;
        m_dat[way * SETS + int'(tag[13:12])] = dat;
        @(negedge clk);
        mnt_we = 1'b0;
    endtask

    task automatic lookup(input string rq, input logic [31:0] va,
                          input logic [1:0] acc, input logic [31:0] ctx);
        logic        e_hit;
        logic [31:0] e_pa;
        logic [2:0]  e_pm;
        logic        e_ok;
        model(va, acc, ctx, e_hit, e_pa, e_pm, e_ok);
        @(negedge clk);
        req_vld   = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        ctx_word  = ctx;
        @(negedge clk);
        req_vld = 1'b0;
        compare(rq, e_hit, e_pa, e_pm, e_ok);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R1", "idle vld",   32'(rsp_vld),  32'd0);
        chk("R1", "idle hit",   32'(rsp_hit),  32'd0);
        chk("R1", "idle paddr", rsp_paddr,     32'd0);
        chk("R1", "idle perm",  32'(rsp_perm), 32'd0);
        chk("R1", "idle ok",    32'(rsp_ok),   32'd0);
    endtask

    function automatic logic [31:0] mk_tag(input logic [19:0] vpn, input bit g,
                                           input bit v, input logic [7:0] pid);
        return {vpn, g, v, 2'b11, pid};
    endfunction

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] vpn1;
        logic        e_hit;
        logic [31:0] e_pa;
        logic [2:0]  e_pm;
        logic        e_ok;

        for (int i = 0; i < ENTRIES; i++) begin
            m_tag[i] = '0;
            m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset: outputs clear
        chk("R1", "reset vld",   32'(rsp_vld),  32'd0);
        chk("R1", "reset hit",   32'(rsp_hit),  32'd0);
        chk("R1", "reset paddr", rsp_paddr,     32'd0);

        // R1 reset: zeroed table hits page 0 with PID 0, frame 0, no permissions
        lookup("R1", 32'h0000_0123, 2'd0, 32'h0);
        idle_check();

        // R2 R3 R5 R6: load every way and set with distinct contents
        for (int w = 0; w < WAYS; w++) begin
            for (int s = 0; s < SETS; s++) begin
                logic [19:0] vpn;
                logic [2:0]  pat;
                logic [31:0] dat;
                vpn = 20'hA5000 | 20'((w + 1) << 4) | 20'(s);
                pat = 3'((w * 4 + s) % 8);
                dat = 32'hFF00_0000 | (32'(s & 1) << 23) | (32'(pat[0]) << 22) |
                      (32'(pat[1]) << 21) | (32'(pat[2]) << 20) |
                      32'(20'h30000 + 20'(w * 16 + s));
                mwrite(w, mk_tag(vpn, (w == 3), 1'b1, 8'(w * 3 + 1)), dat);
            end
        end

        // R3 R4 R5 R6 R9: sweep all entries, all access codes, matching PID
        for (int w = 0; w < WAYS; w++) begin
            for (int s = 0; s < SETS; s++) begin
                for (int a = 0; a < 4; a++) begin
                    logic [19:0] vpn;
                    logic [31:0] va;
                    logic [31:0] ctx;
                    vpn = 20'hA5000 | 20'((w + 1) << 4) | 20'(s);
                    va  = {vpn, 12'((w * 37 + s * 101 + a * 7) & 12'hFFF)};
                    ctx = 32'h5A5A_0000 | (32'(w * 3 + 1) << 4) | 32'(4'hB ^ 4'(a));
                    lookup("R6", va, 2'(a), ctx);
                    // R3 wrong PID: only the global way still hits
                    lookup("R3", va, 2'(a), ctx ^ 32'h0000_0800);
                    // R8 same set, other page: miss
                    lookup("R8", va ^ 32'h0010_0000, 2'(a), ctx);
                end
            end
        end
        idle_check();

        // R4: context bits outside the PID field changed, result unchanged
        lookup("R4", {20'hA5020 | 20'd1, 12'hFFF}, 2'd0, 32'hFFFF_F04F);
        chk("R4", "ctx junk hit", 32'(rsp_hit), 32'd1);

        // R7: three ways of set 1 match, lowest wins
        vpn1 = 20'hA5000 | 20'(2 << 4) | 20'd1;
        mwrite(2, mk_tag(vpn1, 1'b1, 1'b1, 8'h77), 32'h0070_0ABC);
        mwrite(3, mk_tag(vpn1, 1'b0, 1'b1, 8'd4),  32'h0020_0DEF);
        lookup("R7", {vpn1, 12'h010}, 2'd1, 32'd4 << 4);
        chk("R7", "way1 frame", rsp_paddr, {20'h30011, 12'h000});
        mwrite(0, mk_tag(vpn1, 1'b1, 1'b1, 8'h00), 32'h0040_0123);
        lookup("R7", {vpn1, 12'h010}, 2'd0, 32'd4 << 4);
        chk("R7", "way0 frame", rsp_paddr, 32'h0012_3000);

        // R3: valid flag clear still matches
        mwrite(1, mk_tag(20'h12342, 1'b0, 1'b0, 8'h55), 32'h0050_4444);
        lookup("R3", 32'h1234_2ABC, 2'd2, 32'h0000_0550);
        chk("R3", "valid clear hit", 32'(rsp_hit), 32'd1);

        // R10: same-cycle write sees old contents, next lookup sees new
        model(32'h1234_2000, 2'd1, 32'h0000_0550, e_hit, e_pa, e_pm, e_ok);
        @(negedge clk);
        req_vld   = 1'b1;
        req_vaddr = 32'h1234_2000;
        req_acc   = 2'd1;
        ctx_word  = 32'h0000_0550;
        mnt_we    = 1'b1;
        mnt_way   = WAY_W'(1);
        mnt_tag   = mk_tag(20'h12342, 1'b0, 1'b1, 8'h55);
        mnt_data  = 32'h0020_9999;
        m_tag[1 * SETS + 2] = mnt_tag;
        m_dat[1 * SETS + 2] = mnt_data;
        @(negedge clk);
        req_vld = 1'b0;
        mnt_we  = 1'b0;
        compare("R10", e_hit, e_pa, e_pm, e_ok);
        lookup("R10", 32'h1234_2000, 2'd1, 32'h0000_0550);
        chk("R10", "new frame", rsp_paddr, 32'h0999_9000);

        // R2: set index from page bits; same page in other set misses
        lookup("R2", 32'h1234_1000, 2'd0, 32'h0000_0550);
        idle_check();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule